// File: doc/BRIEF.md
# Launch Rendezvous Barrier

This block synchronises one initiating agent and a parameterised number of responding agents during a secure launch. When a launch is requested, the initiator masks its external events. One cycle later it broadcasts a start pulse. Every agent, the initiator included, latches its event mask and exit-enable bits when it sees the start pulse. It then waits until its local integrity checks report done and evaluates them. If they pass, it raises its launched flag, and that flag serves as its acknowledgement.

The acknowledgements form a bitmap. Bit 0 is the initiator and bit i is responder i. The cycle after the bitmap becomes all ones, the initiator issues a one-cycle continue pulse. A one-cycle hold pulse follows, and then a level that lets module loading proceed. On continue, each responder records that its bootstrap indicator is cleared and goes to sleep. Only a wake pulse brings it out of sleep.

A failed integrity check puts that agent into a terminal shutdown state with an 8-bit code. The barrier then never completes.

Top module: `launch_rendezvous`

## Requirements
- R1: A launch request in the idle state sets the initiator's event mask (evt_mask_o bit 0) on the next edge. start_o is a one-cycle pulse on the edge after that, so the mask is already set while start_o is high.
- R2: On the edge after start_o, every agent sets its evt_mask_o and exit_en_o bits, and they stay set.
- R3: An agent evaluates its checks on an edge where its chk_done_i bit is high. If all checks pass, its ack_map_o bit (bit 0 initiator, bit i responder i) rises on that edge and stays set. An agent whose chk_done_i stays low keeps its bit clear.
- R4: cont_o is a one-cycle pulse on the edge after ack_map_o becomes all ones. hold_o is a one-cycle pulse on the following edge, and load_go_o rises on the edge after hold_o and stays high.
- R5: On the edge where cont_o is sampled high, each responder sets its bsp_clr_o and sleep_o bits.
- R6: A wake_i pulse on a sleeping responder clears its sleep_o bit and sets its awake_o bit on the next edge. A wake_i pulse to a responder that is not asleep has no effect.
- R7: An agent whose virt_i bit is high when its checks complete enters shutdown: sd_o is 1 and sd_code_o is 8'h01.
- R8: An agent whose mc_uncorr_i, mc_busy_i or ierr_i bit is high when its checks complete enters shutdown with sd_code_o 8'h0C (12).
- R9: An agent with vid_bad_i high and vid_adj_i low when its checks complete enters shutdown with sd_code_o 8'h02. With vid_adj_i also high, the agent passes.
- R10: Within one agent, the shutdown causes rank virtualization, then machine check, then voltage/ratio. Across agents, the lowest index that is down supplies sd_code_o. While any agent is down, cont_o and load_go_o stay low.
- R11: A launch request after the launch has started or finished is ignored: start_o stays low and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| launch_req_i | input | 1 | Launch request pulse to the initiator |
| chk_done_i | input | NUM_RESP+1 | Per-agent integrity checks complete |
| virt_i | input | NUM_RESP+1 | Per-agent host virtualization active |
| mc_uncorr_i | input | NUM_RESP+1 | Per-agent uncorrectable machine-check status |
| mc_busy_i | input | NUM_RESP+1 | Per-agent machine-check in progress |
| ierr_i | input | NUM_RESP+1 | Per-agent internal-error pin |
| vid_bad_i | input | NUM_RESP+1 | Per-agent voltage/ratio not at a known good value |
| vid_adj_i | input | NUM_RESP+1 | Per-agent voltage/ratio internally adjustable |
| wake_i | input | NUM_RESP | Wake message per responder |
| evt_mask_o | output | NUM_RESP+1 | External events (SMI, INIT, A20M, NMI) masked |
| exit_en_o | output | NUM_RESP+1 | Exit event unmasked |
| ack_map_o | output | NUM_RESP+1 | Acknowledgement bitmap / launched flags |
| start_o | output | 1 | Start broadcast pulse |
| cont_o | output | 1 | Continue broadcast pulse |
| hold_o | output | 1 | Hold broadcast pulse |
| load_go_o | output | 1 | Initiator may proceed to module loading |
| bsp_clr_o | output | NUM_RESP | Responder bootstrap indicator cleared |
| sleep_o | output | NUM_RESP | Responder in sleep |
| awake_o | output | NUM_RESP | Responder woken |
| sd_o | output | 1 | Shutdown flagged |
| sd_code_o | output | 8 | Shutdown error code |

## Verification
The assertions assume the following about the inputs:
- launch_req_i and wake_i are treated as messages, so only their level at an edge matters.
- The check inputs matter only on the edge where the matching chk_done_i bit is high.
- No agent acknowledges without first having seen the start pulse.

The stimulus drives every input on the falling clock edge, so each value is stable across the next rising edge. It holds the check inputs constant from reset through the whole launch and gives each scenario a fresh reset. It delays an acknowledgement only by holding a chk_done_i bit low, and it sends wake pulses both before continue and after sleep.

// File: rtl/lr_pkg.sv
package lr_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] SD_NONE        = 8'h00;
  localparam logic [CODE_W-1:0] SD_ILLEGAL_EVT = 8'h01;
  localparam logic [CODE_W-1:0] SD_BAD_VID     = 8'h02;
  localparam logic [CODE_W-1:0] SD_MCHK        = 8'h0C;

  typedef enum logic [2:0] {
    IC_IDLE, IC_MASK, IC_BCAST, IC_WAIT, IC_CONT, IC_HOLD, IC_LOAD
  } ic_state_e;

  typedef enum logic [1:0] {AG_IDLE, AG_CHECK, AG_DONE, AG_DOWN} ag_state_e;

  typedef enum logic [1:0] {PK_WAIT, PK_SLEEP, PK_AWAKE} pk_state_e;
endpackage

// File: rtl/lr_agent_check.sv
module lr_agent_check
  import lr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              chk_done_i,
  input  logic              virt_i,
  input  logic              mc_uncorr_i,
  input  logic              mc_busy_i,
  input  logic              ierr_i,
  input  logic              vid_bad_i,
  input  logic              vid_adj_i,
  output logic              mask_o,
  output logic              exit_en_o,
  output logic              launched_o,
  output logic              down_o,
  output logic [CODE_W-1:0] code_o
);
  ag_state_e         state_q;
  logic              mask_q, exit_q;
  logic [CODE_W-1:0] code_q;
  logic              mc_fail;

  assign mc_fail = mc_uncorr_i | mc_busy_i | ierr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= AG_IDLE;
      mask_q  <= 1'b0;
      exit_q  <= 1'b0;
      code_q  <= SD_NONE;
    end else begin
      case (state_q)
        AG_IDLE: if (start_i) begin
          mask_q  <= 1'b1;
          exit_q  <= 1'b1;
          state_q <= AG_CHECK;
        end
        AG_CHECK: if (chk_done_i) begin
          if (virt_i) begin
            state_q <= AG_DOWN;
            code_q  <= SD_ILLEGAL_EVT;
          end else if (mc_fail) begin
            state_q <= AG_DOWN;
            code_q  <= SD_MCHK;
          end else if (vid_bad_i && !vid_adj_i) begin
            state_q <= AG_DOWN;
            code_q  <= SD_BAD_VID;
          end else begin
            state_q <= AG_DONE;
          end
        end
        default: ;  // launched or down: start ignored, terminal
      endcase
    end
  end

  assign mask_o     = mask_q;
  assign exit_en_o  = exit_q;
  assign launched_o = (state_q == AG_DONE);
  assign down_o     = (state_q == AG_DOWN);
  assign code_o     = code_q;

  // R3
  ack_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(launched_o) |-> $past(chk_done_i));
  // R2
  ack_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launched_o |-> (mask_o && exit_en_o));
  // R10
  down_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_o |=> (down_o && !launched_o));
endmodule

// File: rtl/lr_resp_park.sv
module lr_resp_park
  import lr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launched_i,
  input  logic cont_i,
  input  logic wake_i,
  output logic bsp_clr_o,
  output logic sleep_o,
  output logic awake_o
);
  pk_state_e state_q;
  logic      bsp_clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PK_WAIT;
      bsp_clr_q <= 1'b0;
    end else begin
      case (state_q)
        PK_WAIT: if (launched_i && cont_i) begin
          bsp_clr_q <= 1'b1;
          state_q   <= PK_SLEEP;
        end
        PK_SLEEP: if (wake_i) state_q <= PK_AWAKE;
        default: ;
      endcase
    end
  end

  assign bsp_clr_o = bsp_clr_q;
  assign sleep_o   = (state_q == PK_SLEEP);
  assign awake_o   = (state_q == PK_AWAKE);

  // R6
  wake_from_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(awake_o) |-> $past(sleep_o && wake_i));
  // R5
  sleep_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(cont_i && launched_i));
endmodule

// File: rtl/lr_init_ctrl.sv
module lr_init_ctrl
  import lr_pkg::*;
#(
  parameter int NA = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_req_i,
  input  logic [NA-1:0] ack_map_i,
  input  logic          sd_i,
  output logic          mask_o,
  output logic          start_o,
  output logic          cont_o,
  output logic          hold_o,
  output logic          load_go_o
);
  ic_state_e state_q, state_d;
  logic      all_ack;

  assign all_ack = &ack_map_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      IC_IDLE:  if (launch_req_i) state_d = IC_MASK;
      IC_MASK:  state_d = IC_BCAST;
      IC_BCAST: state_d = IC_WAIT;
      IC_WAIT:  if (all_ack && !sd_i) state_d = IC_CONT;
      IC_CONT:  state_d = IC_HOLD;
      IC_HOLD:  state_d = IC_LOAD;
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= IC_IDLE;
    else         state_q <= state_d;
  end

  assign mask_o    = (state_q != IC_IDLE);
  assign start_o   = (state_q == IC_BCAST);
  assign cont_o    = (state_q == IC_CONT);
  assign hold_o    = (state_q == IC_HOLD);
  assign load_go_o = (state_q == IC_LOAD);

  // R1
  mask_before_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(mask_o));
  // R4
  cont_after_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cont_o) |-> $past(all_ack));
  // R4
  hold_after_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_o |=> (hold_o && !cont_o));
endmodule

// File: rtl/lr_sd_merge.sv
module lr_sd_merge
  import lr_pkg::*;
#(
  parameter int NA = 4
) (
  input  logic [NA-1:0]             down_i,
  input  logic [NA-1:0][CODE_W-1:0] code_i,
  output logic                      sd_o,
  output logic [CODE_W-1:0]         code_o
);
  // lowest index wins: scan downward, last hit stays
  always_comb begin
    sd_o   = 1'b0;
    code_o = SD_NONE;
    for (int i = NA - 1; i >= 0; i--) begin
      if (down_i[i]) begin
        sd_o   = 1'b1;
        code_o = code_i[i];
      end
    end
  end
endmodule

// File: rtl/launch_rendezvous.sv
module launch_rendezvous
  import lr_pkg::*;
#(
  parameter int NUM_RESP = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                launch_req_i,
  input  logic [NUM_RESP:0]   chk_done_i,
  input  logic [NUM_RESP:0]   virt_i,
  input  logic [NUM_RESP:0]   mc_uncorr_i,
  input  logic [NUM_RESP:0]   mc_busy_i,
  input  logic [NUM_RESP:0]   ierr_i,
  input  logic [NUM_RESP:0]   vid_bad_i,
  input  logic [NUM_RESP:0]   vid_adj_i,
  input  logic [NUM_RESP-1:0] wake_i,
  output logic [NUM_RESP:0]   evt_mask_o,
  output logic [NUM_RESP:0]   exit_en_o,
  output logic [NUM_RESP:0]   ack_map_o,
  output logic                start_o,
  output logic                cont_o,
  output logic                hold_o,
  output logic                load_go_o,
  output logic [NUM_RESP-1:0] bsp_clr_o,
  output logic [NUM_RESP-1:0] sleep_o,
  output logic [NUM_RESP-1:0] awake_o,
  output logic                sd_o,
  output logic [7:0]          sd_code_o
);
  localparam int NA = NUM_RESP + 1;

  logic [NA-1:0]             ag_mask, ag_launched, ag_down;
  logic [NA-1:0][CODE_W-1:0] ag_code;
  logic                      init_mask, start_bc, cont_bc, sd_any;

  lr_init_ctrl #(.NA(NA)) u_init (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_req_i (launch_req_i),
    .ack_map_i    (ag_launched),
    .sd_i         (sd_any),
    .mask_o       (init_mask),
    .start_o      (start_bc),
    .cont_o       (cont_bc),
    .hold_o       (hold_o),
    .load_go_o    (load_go_o)
  );

  for (genvar a = 0; a < NA; a++) begin : g_agent
    lr_agent_check u_chk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_bc),
      .chk_done_i  (chk_done_i[a]),
      .virt_i      (virt_i[a]),
      .mc_uncorr_i (mc_uncorr_i[a]),
      .mc_busy_i   (mc_busy_i[a]),
      .ierr_i      (ierr_i[a]),
      .vid_bad_i   (vid_bad_i[a]),
      .vid_adj_i   (vid_adj_i[a]),
      .mask_o      (ag_mask[a]),
      .exit_en_o   (exit_en_o[a]),
      .launched_o  (ag_launched[a]),
      .down_o      (ag_down[a]),
      .code_o      (ag_code[a])
    );
  end

  for (genvar r = 0; r < NUM_RESP; r++) begin : g_resp
    lr_resp_park u_park (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .launched_i (ag_launched[r+1]),
      .cont_i     (cont_bc),
      .wake_i     (wake_i[r]),
      .bsp_clr_o  (bsp_clr_o[r]),
      .sleep_o    (sleep_o[r]),
      .awake_o    (awake_o[r])
    );
  end

  lr_sd_merge #(.NA(NA)) u_merge (
    .down_i (ag_down),
    .code_i (ag_code),
    .sd_o   (sd_any),
    .code_o (sd_code_o)
  );

  assign evt_mask_o = {ag_mask[NA-1:1], ag_mask[0] | init_mask};
  assign ack_map_o  = ag_launched;
  assign start_o    = start_bc;
  assign cont_o     = cont_bc;
  assign sd_o       = sd_any;

  // R10
  sd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_o |-> (sd_code_o != SD_NONE && !cont_o));
  // R11
  relaunch_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_go_o && launch_req_i) |=> (load_go_o && !start_o));
endmodule

// File: tb/sim_launch_rendezvous.sv
module sim_launch_rendezvous;
  localparam int CLK_P = 10;
  localparam int NR = 3;
  localparam int NA = NR + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          launch_req;
  logic [NA-1:0] chk_done, virt, mc_uncorr, mc_busy, ierr, vid_bad, vid_adj;
  logic [NR-1:0] wake;
  logic [NA-1:0] evt_mask, exit_en, ack_map;
  logic          start, cont, hold, load_go, sd;
  logic [NR-1:0] bsp_clr, sleep, awake;
  logic [7:0]    sd_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  launch_rendezvous #(.NUM_RESP(NR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .launch_req_i(launch_req),
    .chk_done_i(chk_done), .virt_i(virt), .mc_uncorr_i(mc_uncorr),
    .mc_busy_i(mc_busy), .ierr_i(ierr), .vid_bad_i(vid_bad), .vid_adj_i(vid_adj),
    .wake_i(wake), .evt_mask_o(evt_mask), .exit_en_o(exit_en), .ack_map_o(ack_map),
    .start_o(start), .cont_o(cont), .hold_o(hold), .load_go_o(load_go),
    .bsp_clr_o(bsp_clr), .sleep_o(sleep), .awake_o(awake),
    .sd_o(sd), .sd_code_o(sd_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    launch_req = 1'b0;
    chk_done = '1; virt = '0; mc_uncorr = '0; mc_busy = '0; ierr = '0;
    vid_bad = '0; vid_adj = '0; wake = '0;
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  // lands after the edge on which agents evaluate checks
  task automatic launch_to_check();
    launch_req = 1'b1;
    step();
    launch_req = 1'b0;
    step(); step(); step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset mask", evt_mask, 0);
    chk("R3 reset ack", ack_map, 0);
    chk("R4 reset start/cont/hold/load", {start, cont, hold, load_go}, 0);
    chk("R5 reset sleep", sleep, 0);
    chk("R10 reset sd", {sd, sd_code}, 0);
  endtask

  task automatic t_normal();
    do_reset();
    launch_req = 1'b1;
    step();
    launch_req = 1'b0;
    chk("R1 init mask first", evt_mask, 4'b0001);
    chk("R1 no start yet", start, 0);
    step();
    chk("R1 start pulse", start, 1);
    step();
    chk("R2 all masked", evt_mask, 4'hF);
    chk("R2 exit enabled", exit_en, 4'hF);
    chk("R1 start one cycle", start, 0);
    step();
    chk("R3 ack full", ack_map, 4'hF);
    chk("R4 no cont yet", cont, 0);
    step();
    chk("R4 cont", cont, 1);
    chk("R5 not asleep yet", sleep, 0);
    step();
    chk("R4 hold after cont", {hold, cont}, 2'b10);
    chk("R5 sleep", sleep, 3'b111);
    chk("R5 bsp cleared", bsp_clr, 3'b111);
    step();
    chk("R4 load go", {load_go, hold}, 2'b10);
    wake = 3'b010;
    step();
    wake = '0;
    chk("R6 awake", awake, 3'b010);
    chk("R6 sleep others", sleep, 3'b101);
    launch_req = 1'b1;
    step();
    launch_req = 1'b0;
    chk("R11 no restart", start, 0);
    step(); step();
    chk("R11 state kept", {load_go, ack_map, evt_mask, sleep, awake, sd}, {1'b1, 4'hF, 4'hF, 3'b101, 3'b010, 1'b0});
  endtask

  task automatic t_straggler();
    do_reset();
    chk_done = 4'b1011;
    launch_to_check();
    chk("R3 partial ack", ack_map, 4'b1011);
    step(); step();
    chk("R4 no cont partial", cont, 0);
    wake = 3'b111;
    step();
    wake = '0;
    chk("R6 wake ignored awake", awake, 0);
    chk("R6 wake ignored sleep", sleep, 0);
    chk_done = 4'hF;
    step();
    chk("R3 late ack", ack_map, 4'hF);
    step();
    chk("R4 cont after late ack", cont, 1);
  endtask

  task automatic t_virt();
    do_reset();
    virt = 4'b0100;
    launch_to_check();
    chk("R7 sd", sd, 1);
    chk("R7 code", sd_code, 8'h01);
    chk("R7 others ack", ack_map, 4'b1011);
    step(); step(); step();
    chk("R10 barrier frozen", {cont, load_go, sleep}, 0);
  endtask

  task automatic t_mchk();
    for (int k = 0; k < 3; k++) begin
      do_reset();
      if (k == 0) mc_uncorr = 4'b1000;
      else if (k == 1) mc_busy = 4'b0001;
      else ierr = 4'b0100;
      launch_to_check();
      chk("R8 sd", sd, 1);
      chk("R8 code 12", sd_code, 8'h0C);
    end
  endtask

  task automatic t_vid();
    do_reset();
    vid_bad = 4'b0010;
    launch_to_check();
    chk("R9 vid shutdown", {sd, sd_code}, {1'b1, 8'h02});
    do_reset();
    vid_bad = 4'b0010;
    vid_adj = 4'b0010;
    launch_to_check();
    chk("R9 adjustable passes", {sd, ack_map}, {1'b0, 4'hF});
    step();
    chk("R9 cont after adjust", cont, 1);
  endtask

  task automatic t_priority();
    do_reset();
    vid_bad = 4'b0010;
    virt = 4'b1000;
    launch_to_check();
    chk("R10 lowest index code", sd_code, 8'h02);
    do_reset();
    virt = 4'b0100;
    mc_busy = 4'b0100;
    vid_bad = 4'b0100;
    launch_to_check();
    chk("R10 virt over mc/vid", sd_code, 8'h01);
    do_reset();
    mc_uncorr = 4'b0001;
    vid_bad = 4'b0001;
    launch_to_check();
    chk("R10 mc over vid", sd_code, 8'h0C);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_normal();
    t_straggler();
    t_virt();
    t_mchk();
    t_vid();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule